// File: doc/BRIEF.md
# Boot Overlay Chip-Select Decoder

This block generates the ROM and RAM chip selects for a small 8-bit processor system with a 16-bit address bus. A 4 KB monitor ROM normally occupies only the top 4 KB page, $F000 to $FFFF. Right after reset, a boot-overlay flag is raised, and the ROM also answers in every other page. The processor can then fetch its first instructions at address zero from the ROM.

The monitor program leaves the overlay by making any I/O cycle, read or write, to the clear port. From the next clock edge onward, the lower fifteen pages belong to RAM. Software cannot raise the flag again. Only reset brings the overlay back.

The ROM select is qualified by the memory-read strobe. The RAM select covers memory reads and writes outside the ROM window. A memory write that lands in the window therefore reaches neither device.

Top module: `boot_overlay_decoder`

## Requirements
- R1: After reset, a memory read in any page (address bits [15:12] = 0..F) drives rom_sel high and ram_sel low.
- R2: A memory read with address bits [15:12] = 4'hF always drives rom_sel high, whether or not the overlay is active.
- R3: An I/O read with address bits [7:0] = 8'hF8 clears the overlay from the next rising clock edge. After that, memory reads in pages 0..E drive ram_sel high and rom_sel low.
- R4: An I/O write to port 8'hF8 clears the overlay in the same way as an I/O read.
- R5: A memory read or memory write at an address whose low byte is 8'hF8 leaves the overlay unchanged.
- R6: An I/O cycle to any port other than 8'hF8 leaves the overlay unchanged.
- R7: rom_sel is high only during a memory read. A memory write inside the ROM window (page F, or any page while the overlay is active) drives both selects low.
- R8: ram_sel is high only during a memory read or write outside the ROM window. rom_sel and ram_sel are never high together.
- R9: Once cleared, the overlay stays cleared under any further I/O or memory traffic, including more accesses to port 8'hF8. Only reset raises it again.
- R10: With no strobe active, including during I/O cycles, both selects are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; raises the boot overlay |
| addr | input | 16 | Processor address bus; bits [7:0] carry the port number in I/O cycles |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| rom_sel | output | 1 | Monitor ROM select, active high |
| ram_sel | output | 1 | RAM select, active high |

## Verification
The assertions assume that at most one of the four strobes is high in any cycle, as on a processor bus. They also assume that the address and strobes are stable across each clock edge. The bench drives one bus cycle per clock, changing inputs on the falling edge, and never raises two strobes at once. It covers every page with and without the overlay, clear-port hits and near-misses from both I/O and memory cycles, and a second reset after clearing.

// File: rtl/bootdec_pkg.sv
package bootdec_pkg;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
  } bus_cyc_t;

  function automatic logic is_mem(bus_cyc_t c);
    return c.mem_rd | c.mem_wr;
  endfunction

  function automatic logic is_io(bus_cyc_t c);
    return c.io_rd | c.io_wr;
  endfunction

  // the ROM window: top page always, every page while the overlay is raised
  function automatic logic in_window(logic top_page, logic overlay);
    return top_page | overlay;
  endfunction

endpackage

// File: rtl/io_port_match.sv
module io_port_match
  import bootdec_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] CLR_PORT = 8'hF8
) (
  input  logic [PORT_W-1:0] port,
  input  bus_cyc_t          cyc,
  output logic              clr_hit
);
  always_comb clr_hit = is_io(cyc) && (port == CLR_PORT);
endmodule

// File: rtl/boot_flag.sv
module boot_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic overlay
);
  // set only by reset; software can only clear it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   overlay <= 1'b1;
    else if (clr) overlay <= 1'b0;
  end
endmodule

// File: rtl/window_decode.sv
module window_decode
  import bootdec_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input  logic [PAGE_W-1:0] page,
  input  logic              overlay,
  input  bus_cyc_t          cyc,
  output logic              window,
  output logic              rom_sel,
  output logic              ram_sel
);
  localparam logic [PAGE_W-1:0] TOP_PAGE = {PAGE_W{1'b1}};

  always_comb begin
    window  = in_window(page == TOP_PAGE, overlay);
    rom_sel = cyc.mem_rd & window;
    ram_sel = is_mem(cyc) & ~window;
  end
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import bootdec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] CLR_PORT = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic              rom_sel,
  output logic              ram_sel
);
  localparam int MID_LO = PORT_W;
  localparam int MID_HI = ADDR_W - PAGE_W - 1;

  bus_cyc_t          cyc;
  logic [PAGE_W-1:0] page;
  logic [PORT_W-1:0] port;
  logic              clr_hit;
  logic              overlay_on;
  logic              rom_window;
  logic              unused_mid;

  always_comb begin
    cyc        = '{mem_rd: mem_rd, mem_wr: mem_wr, io_rd: io_rd, io_wr: io_wr};
    page       = addr[ADDR_W-1 -: PAGE_W];
    port       = addr[PORT_W-1:0];
    unused_mid = ^addr[MID_HI:MID_LO];
  end

  io_port_match #(.PORT_W(PORT_W), .CLR_PORT(CLR_PORT)) u_match (
    .port(port), .cyc(cyc), .clr_hit(clr_hit)
  );

  boot_flag u_flag (
    .clk(clk), .rst_n(rst_n), .clr(clr_hit), .overlay(overlay_on)
  );

  window_decode #(.PAGE_W(PAGE_W)) u_win (
    .page(page), .overlay(overlay_on), .cyc(cyc),
    .window(rom_window), .rom_sel(rom_sel), .ram_sel(ram_sel)
  );
endmodule

// File: rtl/boot_overlay_checker.sv
module boot_overlay_checker #(
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PAGE_W-1:0] page,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              io_rd,
  input logic              io_wr,
  input logic              clr_hit,
  input logic              overlay_on,
  input logic              rom_sel,
  input logic              ram_sel
);
  localparam logic [PAGE_W-1:0] TOP_PAGE = {PAGE_W{1'b1}};

  p_one_strobe_in: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr}));

  p_boot_any_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (overlay_on && mem_rd) |-> rom_sel);

  p_top_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && page == TOP_PAGE) |-> rom_sel);

  p_clear_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !overlay_on);

  p_hold_no_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (overlay_on && !clr_hit) |=> overlay_on);

  p_rom_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> mem_rd);

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel && ram_sel));

  p_ram_mem_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> (mem_rd || mem_wr));

  p_no_reraise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !overlay_on |=> !overlay_on);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd || mem_wr) |-> !(rom_sel || ram_sel));
endmodule

bind boot_overlay_decoder boot_overlay_checker #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .page(page),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
  .clr_hit(clr_hit), .overlay_on(overlay_on),
  .rom_sel(rom_sel), .ram_sel(ram_sel)
);

// File: tb/test_boot_overlay_decoder.sv
module test_boot_overlay_decoder;
  typedef enum logic [2:0] {IDLE, MRD, MWR, IORD, IOWR} kind_t;
  typedef struct {
    logic  rom;
    logic  ram;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        mem_rd = 1'b0, mem_wr = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
  logic        rom_sel, ram_sel;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   model_ov = 1'b1;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  boot_overlay_decoder i_boot_overlay_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .rom_sel(rom_sel), .ram_sel(ram_sel)
  );

  // driver: one bus cycle per clock, expected result pushed to the scoreboard
  task automatic drive(kind_t k, logic [15:0] a, string tag);
    exp_t e;
    bit   win;
    @(negedge clk);
    addr   = a;
    mem_rd = (k == MRD);
    mem_wr = (k == MWR);
    io_rd  = (k == IORD);
    io_wr  = (k == IOWR);
    win    = (a[15:12] == 4'hF) || model_ov;
    e.rom  = (k == MRD) && win;
    e.ram  = (k == MRD || k == MWR) && !win;
    e.tag  = tag;
    exp_q.push_back(e);
    if ((k == IORD || k == IOWR) && a[7:0] == 8'hF8) model_ov = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    {mem_rd, mem_wr, io_rd, io_wr} = '0;
    rst_n = 1'b0;
    model_ov = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: compares outputs in the middle of the low clock phase
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (rom_sel !== e.rom || ram_sel !== e.ram) begin
          n_bad++;
          $display("FAIL %s: rom_sel/ram_sel = %b/%b, expected %b/%b",
                   e.tag, rom_sel, ram_sel, e.rom, e.ram);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: overlay covers every page after reset
    for (int p = 0; p < 16; p++) drive(MRD, 16'(p << 12) | 16'h0123, "R1");
    // R10: idle and I/O to other ports leave both selects low
    drive(IDLE, 16'h0000, "R10");
    drive(IORD, 16'h00E0, "R10");
    // R7: writes inside the window reach neither device
    drive(MWR, 16'h0000, "R7");
    drive(MWR, 16'h5555, "R7");
    drive(MWR, 16'hF000, "R7");
    // R5: memory cycles at low byte F8 do not clear
    drive(MRD, 16'h00F8, "R5");
    drive(MWR, 16'h12F8, "R5");
    drive(MRD, 16'h2000, "R5");
    // R6: I/O near-misses do not clear
    drive(IOWR, 16'h00F9, "R6");
    drive(IORD, 16'h00F0, "R6");
    drive(IOWR, 16'hF878, "R6");
    drive(MRD, 16'h3000, "R6");
    // R3: I/O read to the clear port
    drive(IORD, 16'h00F8, "R3");
    drive(MRD, 16'h0000, "R3");
    for (int p = 0; p < 15; p++) drive(MRD, 16'(p << 12) | 16'h0FFF, "R3");
    // R2: top page still ROM after clearing
    drive(MRD, 16'hF000, "R2");
    drive(MRD, 16'hFFFF, "R2");
    drive(MWR, 16'hF800, "R7");
    // R8: writes below top now go to RAM
    drive(MWR, 16'h0000, "R8");
    drive(MWR, 16'hE123, "R8");
    // R9: no traffic raises the overlay again
    drive(IOWR, 16'h00F8, "R9");
    drive(IORD, 16'h00F8, "R9");
    drive(IOWR, 16'h0000, "R9");
    drive(MWR, 16'h00F8, "R9");
    drive(MRD, 16'h1000, "R9");
    drive(IDLE, 16'h1000, "R10");
    // R4: reset brings the overlay back; an I/O write clears it
    @(negedge clk);
    do_reset();
    drive(MRD, 16'h4000, "R1");
    drive(IOWR, 16'hABF8, "R4");
    drive(MRD, 16'h4000, "R4");
    drive(MRD, 16'hF123, "R2");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule